// File: doc/BRIEF.md
# FPM DRAM Initialization and Refresh Controller

This block drives an asynchronous fast-page-mode DRAM of 1M words by 4 bits through a 10-bit multiplexed address bus and four active-low strobes (row strobe, column strobe, write enable, output enable). A host issues single requests over a valid/ready handshake. Each request is a read, an early write or a read-modify-write, and carries its row, column and write data. A request marked as not last leaves the row open, so that a following request to the same row runs as a column-only page cycle.

Out of reset the controller holds every strobe inactive for a power-up pause. It then runs a fixed number of refresh cycles in which the column strobe falls before the row strobe, and only after that does it accept host requests. From then on an interval timer raises refresh requests. A pending refresh wins at the next idle point, and it closes an open page first. Every strobe interval is a parameter counted in clock cycles. Read data is sampled after the slower of the row-access and column-access paths and is returned with a one-cycle valid pulse.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: For PAUSE_CYC clock cycles after reset release, ras_n, cas_n, we_n and oe_n stay high, req_ready stays low and no row strobe falls.
- R2: After the pause, exactly INIT_REFRESHES refresh cycles run before init_done and req_ready can rise. In each one cas_n falls at least one cycle before ras_n falls, and no row-strobe fall with cas_n high occurs before init_done.
- R3: A read (req_op=0) drives the row on dram_addr when ras_n falls and the column when cas_n falls, with oe_n low and we_n high. It returns the DRAM data on rd_data with rd_valid high for one cycle.
- R4: An early write (req_op=1) drives we_n low and the data bus at least one cycle before cas_n falls, and keeps oe_n high for the whole cycle.
- R5: A read-modify-write (req_op=2) returns the old cell contents on rd_data. Then, within the same row-strobe low period, it writes req_wdata by taking we_n low while cas_n is low.
- R6: dram_dq_oe is never high while oe_n is low. In a read-modify-write, oe_n is high for at least one cycle with the bus released before the data is driven.
- R7: A request with req_last=0 leaves ras_n low. A following request to the same row runs with no new fall of ras_n.
- R8: An open page is closed, with ras_n rising, when a request targets a different row or when a further column cycle would push the row-strobe low time past T_RASP_MAX. ras_n is never low for more than T_RASP_MAX consecutive cycles.
- R9: After init_done a refresh is requested every REFI_CYC cycles. A pending refresh is served before new host requests and closes an open page without waiting for the T_RASP_MAX limit.
- R10: ras_n stays high for at least T_RP cycles between low periods, and in access cycles cas_n falls no earlier than T_RCD cycles after ras_n falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_op | input | 2 | 0 read, 1 early write, 2 read-modify-write |
| req_row | input | 10 | Row address |
| req_col | input | 10 | Column address |
| req_wdata | input | 4 | Write data |
| req_last | input | 1 | 1 closes the row after this access, 0 keeps the page open |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| rd_data | output | 4 | Read data returned to the host |
| init_done | output | 1 | Power-up pause and initialization refreshes complete |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Controller drives the data bus |
| dram_dq_in | input | 4 | Data returned by the DRAM |

## Verification
The hardest situation to reach from the ports is a refresh falling due while a page is held open. The refresh timer runs freely and cannot be seen directly. The bench therefore waits for a refresh to be observed on the strobes, counts most of one interval, and then opens a page with req_last=0 just before the next refresh falls due. The page limit is set well above the distance to that refresh, so a refresh that shows up quickly shows that it closed the page itself. Page-limit closing is reached the same way, with the page opened straight after a refresh so that the limit expires first.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_EWRITE = 2'd1,
    OP_RMW    = 2'd2
  } dram_op_e;

  typedef enum logic [3:0] {
    S_PAUSE, S_REF_CAS, S_REF_RAS, S_REF_PRE,
    S_IDLE, S_ROW, S_WSU, S_COL, S_RMW_OFF, S_RMW_WR,
    S_CPRE, S_PAGE, S_RPRE
  } seq_state_e;

  // cycles the column strobe must stay low before read data is valid:
  // the slower of the column access and the rest of the row access
  function automatic int unsigned col_access_cycles(input int unsigned rcd,
                                                    input int unsigned cac,
                                                    input int unsigned rac);
    int unsigned from_row;
    from_row = (rac > rcd) ? rac - rcd : 32'd0;
    return (cac > from_row) ? cac : from_row;
  endfunction

  // longest column operation started from an open page
  function automatic int unsigned worst_col_op(input int unsigned col_cyc,
                                               input int unsigned cas,
                                               input int unsigned cp);
    return 32'd1 + col_cyc + 32'd1 + cas + cp;
  endfunction

  // one more column op (plus the page decision cycle) still fits
  function automatic logic page_room(input int unsigned low_done,
                                     input int unsigned worst,
                                     input int unsigned rasp);
    return (low_done + worst + 32'd1) < rasp;
  endfunction

endpackage

// File: rtl/dram_ctrl_timers.sv
module dram_ctrl_timers #(
  parameter int unsigned PAUSE_CYC = 5000,
  parameter int unsigned REFI_CYC  = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_refresh,
  input  logic ref_ack,
  output logic pause_done,
  output logic ref_pend
);
  localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned RW = $clog2(REFI_CYC + 1);

  logic [PW-1:0] pause_cnt;
  logic [RW-1:0] refi_cnt;
  logic          refi_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_cnt  <= '0;
      pause_done <= 1'b0;
    end else if (!pause_done) begin
      pause_cnt <= pause_cnt + 1'b1;
      if (pause_cnt == PW'(PAUSE_CYC - 1)) pause_done <= 1'b1;
    end
  end

  assign refi_wrap = run_refresh && (refi_cnt == RW'(REFI_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refi_cnt <= '0;
      ref_pend <= 1'b0;
    end else begin
      if (!run_refresh || refi_wrap) refi_cnt <= '0;
      else                           refi_cnt <= refi_cnt + 1'b1;
      if (refi_wrap)    ref_pend <= 1'b1;
      else if (ref_ack) ref_pend <= 1'b0;
    end
  end

  // R9
  ack_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> ref_pend);

  // R1
  pause_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_done |=> pause_done);

endmodule

// File: rtl/dram_ctrl_seq.sv
module dram_ctrl_seq
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned INIT_REFRESHES = 8,
  parameter int unsigned T_RP       = 3,
  parameter int unsigned T_RCD      = 2,
  parameter int unsigned T_RAC      = 4,
  parameter int unsigned T_CAC      = 2,
  parameter int unsigned T_CAS      = 2,
  parameter int unsigned T_CP       = 1,
  parameter int unsigned T_CSR      = 1,
  parameter int unsigned T_RAS_REF  = 4,
  parameter int unsigned T_RASP_MAX = 600,
  parameter int unsigned AW         = 10,
  parameter int unsigned DQW        = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pause_done,
  input  logic           ref_pend,
  output logic           ref_ack,
  output logic           init_done,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_op,
  input  logic [AW-1:0]  req_row,
  input  logic [AW-1:0]  req_col,
  input  logic [DQW-1:0] req_wdata,
  input  logic           req_last,
  output logic           rd_valid,
  output logic [DQW-1:0] rd_data,
  output logic [AW-1:0]  dram_addr,
  output logic           dram_ras_n,
  output logic           dram_cas_n,
  output logic           dram_we_n,
  output logic           dram_oe_n,
  output logic [DQW-1:0] dram_dq_out,
  output logic           dram_dq_oe,
  input  logic [DQW-1:0] dram_dq_in
);
  localparam int unsigned COL_CYC = col_access_cycles(T_RCD, T_CAC, T_RAC);
  localparam int unsigned WORST   = worst_col_op(COL_CYC, T_CAS, T_CP);
  localparam int unsigned DW      = $clog2(T_RASP_MAX + 1);
  localparam int unsigned IW      = $clog2(INIT_REFRESHES + 1);

  seq_state_e     state, nxt;
  logic [DW-1:0]  dly;
  logic [DW-1:0]  ras_cnt;
  logic [IW-1:0]  init_cnt;
  dram_op_e       cur_op;
  logic [AW-1:0]  cur_row, cur_col;
  logic [DQW-1:0] cur_wd;
  logic           cur_last;

  // named internal events
  logic st_done, accept, capture, room, row_hit, init_last, in_ref, is_ewr;

  function automatic logic [DW-1:0] hold_for(input seq_state_e s);
    case (s)
      S_REF_CAS: return DW'(T_CSR - 1);
      S_REF_RAS: return DW'(T_RAS_REF - 1);
      S_REF_PRE: return DW'(T_RP - 1);
      S_ROW:     return DW'(T_RCD - 1);
      S_COL:     return DW'(COL_CYC - 1);
      S_RMW_WR:  return DW'(T_CAS - 1);
      S_CPRE:    return DW'(T_CP - 1);
      S_RPRE:    return DW'(T_RP - 1);
      default:   return '0;
    endcase
  endfunction

  assign st_done   = (dly == '0);
  assign room      = page_room(32'(ras_cnt), WORST, T_RASP_MAX);
  assign row_hit   = (req_row == cur_row);
  assign init_last = (init_cnt == IW'(INIT_REFRESHES - 1));
  assign in_ref    = (state == S_REF_RAS);
  assign is_ewr    = (cur_op == OP_EWRITE);

  always_comb begin
    req_ready = 1'b0;
    case (state)
      S_IDLE:  req_ready = !ref_pend;
      S_PAGE:  req_ready = !ref_pend && room && row_hit;
      default: req_ready = 1'b0;
    endcase
  end

  assign accept  = req_valid && req_ready;
  assign ref_ack = (state == S_IDLE) && ref_pend;
  assign capture = (state == S_COL) && st_done && !is_ewr;

  always_comb begin
    nxt = state;
    case (state)
      S_PAUSE:   if (pause_done) nxt = S_REF_CAS;
      S_REF_CAS: if (st_done) nxt = S_REF_RAS;
      S_REF_RAS: if (st_done) nxt = S_REF_PRE;
      S_REF_PRE: if (st_done) nxt = (init_done || init_last) ? S_IDLE : S_REF_CAS;
      S_IDLE: begin
        if (ref_pend)       nxt = S_REF_CAS;
        else if (req_valid) nxt = S_ROW;
      end
      S_ROW:     if (st_done) nxt = is_ewr ? S_WSU : S_COL;
      S_WSU:     nxt = S_COL;
      S_COL:     if (st_done) nxt = (cur_op == OP_RMW) ? S_RMW_OFF : S_CPRE;
      S_RMW_OFF: nxt = S_RMW_WR;
      S_RMW_WR:  if (st_done) nxt = S_CPRE;
      S_CPRE:    if (st_done) nxt = cur_last ? S_RPRE : S_PAGE;
      S_PAGE: begin
        if (ref_pend || !room) nxt = S_RPRE;
        else if (accept)       nxt = (dram_op_e'(req_op) == OP_EWRITE) ? S_WSU : S_COL;
        else if (req_valid)    nxt = S_RPRE;
      end
      S_RPRE:    if (st_done) nxt = S_IDLE;
      default:   nxt = S_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_PAUSE;
      dly       <= '0;
      init_cnt  <= '0;
      init_done <= 1'b0;
      cur_op    <= OP_READ;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_wd    <= '0;
      cur_last  <= 1'b1;
      ras_cnt   <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (state != nxt) begin
        state <= nxt;
        dly   <= hold_for(nxt);
      end else if (!st_done) begin
        dly <= dly - 1'b1;
      end
      if (state == S_REF_PRE && st_done && !init_done) begin
        if (init_last) init_done <= 1'b1;
        else           init_cnt  <= init_cnt + 1'b1;
      end
      if (accept) begin
        cur_op   <= dram_op_e'(req_op);
        cur_row  <= req_row;
        cur_col  <= req_col;
        cur_wd   <= req_wdata;
        cur_last <= req_last;
      end
      if (dram_ras_n)                    ras_cnt <= '0;
      else if (ras_cnt != DW'(T_RASP_MAX)) ras_cnt <= ras_cnt + 1'b1;
      rd_valid <= capture;
      if (capture) rd_data <= dram_dq_in;
    end
  end

  // strobe decode from the state register
  always_comb begin
    dram_ras_n  = !(state inside {S_REF_RAS, S_ROW, S_WSU, S_COL, S_RMW_OFF,
                                  S_RMW_WR, S_CPRE, S_PAGE});
    dram_cas_n  = !(state inside {S_REF_CAS, S_REF_RAS, S_COL, S_RMW_OFF, S_RMW_WR});
    dram_we_n   = !((state == S_WSU) || (state == S_COL && is_ewr) || (state == S_RMW_WR));
    dram_oe_n   = !(state == S_COL && !is_ewr);
    dram_dq_oe  = (state == S_WSU) || (state == S_COL && is_ewr) || (state == S_RMW_WR);
    dram_dq_out = cur_wd;
    case (state)
      S_ROW:                        dram_addr = cur_row;
      S_WSU, S_COL, S_RMW_OFF,
      S_RMW_WR, S_CPRE, S_PAGE:     dram_addr = cur_col;
      default:                      dram_addr = '0;
    endcase
  end

  // R1
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !req_ready);

  // R2
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) && in_ref |-> !dram_cas_n && $past(!dram_cas_n));

  // R2
  ready_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done);

  // R4
  ewrite_we_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) && !dram_we_n |-> $past(!dram_we_n) && dram_oe_n);

  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> dram_oe_n);

  // R8
  rasp_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> 32'(ras_cnt) < T_RASP_MAX);

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int unsigned PAUSE_CYC      = 5000,
  parameter int unsigned INIT_REFRESHES = 8,
  parameter int unsigned REFI_CYC       = 780,
  parameter int unsigned T_RP           = 3,
  parameter int unsigned T_RCD          = 2,
  parameter int unsigned T_RAC          = 4,
  parameter int unsigned T_CAC          = 2,
  parameter int unsigned T_CAS          = 2,
  parameter int unsigned T_CP           = 1,
  parameter int unsigned T_CSR          = 1,
  parameter int unsigned T_RAS_REF      = 4,
  parameter int unsigned T_RASP_MAX     = 600,
  parameter int unsigned AW             = 10,
  parameter int unsigned DQW            = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_op,
  input  logic [AW-1:0]  req_row,
  input  logic [AW-1:0]  req_col,
  input  logic [DQW-1:0] req_wdata,
  input  logic           req_last,
  output logic           rd_valid,
  output logic [DQW-1:0] rd_data,
  output logic           init_done,
  output logic [AW-1:0]  dram_addr,
  output logic           dram_ras_n,
  output logic           dram_cas_n,
  output logic           dram_we_n,
  output logic           dram_oe_n,
  output logic [DQW-1:0] dram_dq_out,
  output logic           dram_dq_oe,
  input  logic [DQW-1:0] dram_dq_in
);
  logic pause_done, ref_pend, ref_ack;

  dram_ctrl_timers #(
    .PAUSE_CYC (PAUSE_CYC),
    .REFI_CYC  (REFI_CYC)
  ) timers_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_refresh (init_done),
    .ref_ack     (ref_ack),
    .pause_done  (pause_done),
    .ref_pend    (ref_pend)
  );

  dram_ctrl_seq #(
    .INIT_REFRESHES (INIT_REFRESHES),
    .T_RP       (T_RP),
    .T_RCD      (T_RCD),
    .T_RAC      (T_RAC),
    .T_CAC      (T_CAC),
    .T_CAS      (T_CAS),
    .T_CP       (T_CP),
    .T_CSR      (T_CSR),
    .T_RAS_REF  (T_RAS_REF),
    .T_RASP_MAX (T_RASP_MAX),
    .AW         (AW),
    .DQW        (DQW)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pause_done  (pause_done),
    .ref_pend    (ref_pend),
    .ref_ack     (ref_ack),
    .init_done   (init_done),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_row     (req_row),
    .req_col     (req_col),
    .req_wdata   (req_wdata),
    .req_last    (req_last),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .dram_addr   (dram_addr),
    .dram_ras_n  (dram_ras_n),
    .dram_cas_n  (dram_cas_n),
    .dram_we_n   (dram_we_n),
    .dram_oe_n   (dram_oe_n),
    .dram_dq_out (dram_dq_out),
    .dram_dq_oe  (dram_dq_oe),
    .dram_dq_in  (dram_dq_in)
  );

endmodule

// File: tb/fpm_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb_top;
  localparam int PAUSE = 5000, NINIT = 8, REFI = 780, TRP = 3, TRCD = 2, RASP = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_last = 1'b1;
  logic [1:0] req_op = 2'd0;
  logic [9:0] req_row = '0, req_col = '0;
  logic [3:0] req_wdata = '0;
  logic req_ready, rd_valid, init_done;
  logic [3:0] rd_data, dq_out, dq_in;
  logic [9:0] addr;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;

  fpm_dram_ctrl #(.PAUSE_CYC(PAUSE), .INIT_REFRESHES(NINIT), .REFI_CYC(REFI),
                  .T_RP(TRP), .T_RCD(TRCD), .T_RASP_MAX(RASP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .req_last(req_last), .rd_valid(rd_valid), .rd_data(rd_data), .init_done(init_done),
    .dram_addr(addr), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_oe_n(oe_n), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  // DRAM model and strobe monitor, sampled at the falling clock edge
  logic [3:0] mem [int];
  logic [3:0] shadow [int];
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
  logic [9:0] m_row = '0, m_col = '0;
  int cbr_cnt = 0, act_cnt = 0, early_err = 0, oe_err = 0, rp_err = 0, rcd_err = 0;
  int hi_run = 1000, lo_run = 0, lo_max = 0;
  initial dq_in = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        if (!cas_n) cbr_cnt++;
        else begin act_cnt++; m_row = addr; end
        if (hi_run < TRP) rp_err++;
        lo_run = 0;
      end
      if (!ras_n) begin lo_run++; if (lo_run > lo_max) lo_max = lo_run; hi_run = 0; end
      else hi_run++;
      if (p_cas && !cas_n && !ras_n) begin
        m_col = addr;
        if (lo_run <= TRCD) rcd_err++;
        if (!we_n) begin
          if (p_we) early_err++;
          mem[{m_row, m_col}] = dq_out;
        end
      end
      if (p_we && !we_n && !cas_n && !p_cas) mem[{m_row, m_col}] = dq_out;
      if (dq_oe && !oe_n) oe_err++;
      if (!we_n && !oe_n) oe_err++;
      if (!cas_n && !oe_n && we_n && !ras_n)
        dq_in <= mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : 4'h0;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n;
    end
  end

  int checks = 0, errs = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [9:0] r, input logic [9:0] c,
                      input logic [3:0] wd, input logic lst);
    int t;
    @(negedge clk);
    req_op = op; req_row = r; req_col = c; req_wdata = wd; req_last = lst;
    req_valid = 1'b1;
    #1;
    t = 0;
    while (!req_ready && t < 3000) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic get_rd(output logic [3:0] d, output bit got);
    got = 0; d = '0;
    for (int i = 0; i < 200 && !got; i++) begin
      if (rd_valid) begin got = 1; d = rd_data; end
      else @(negedge clk);
    end
    @(negedge clk);
  endtask

  function automatic logic [3:0] expect_at(input logic [9:0] r, input logic [9:0] c);
    return shadow.exists({r, c}) ? shadow[{r, c}] : 4'h0;
  endfunction

  // issue one request and check returned data against the shadow copy
  task automatic access(input logic [1:0] op, input logic [9:0] r, input logic [9:0] c,
                        input logic [3:0] wd, input logic lst, input string req);
    logic [3:0] d, e;
    bit got;
    e = expect_at(r, c);
    send(op, r, c, wd, lst);
    if (op != 2'd1) begin
      get_rd(d, got);
      chk(got && d == e, req, int'(d), int'(e));
    end else repeat (8) @(negedge clk);
    if (op != 2'd0) shadow[{r, c}] = wd;
  endtask

  task automatic sync_refresh();
    int c0;
    c0 = cbr_cnt;
    for (int i = 0; i < 2000 && cbr_cnt == c0; i++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0] op; logic [9:0] row; logic [9:0] col; logic [3:0] wd; logic last;
  } vec_t;
  localparam vec_t VECS [12] = '{
    '{2'd1, 10'd5,   10'd3,    4'hA, 1'b1},
    '{2'd1, 10'd5,   10'd4,    4'h5, 1'b1},
    '{2'd1, 10'd900, 10'd1023, 4'hF, 1'b1},
    '{2'd0, 10'd5,   10'd3,    4'h0, 1'b1},
    '{2'd0, 10'd900, 10'd1023, 4'h0, 1'b1},
    '{2'd2, 10'd5,   10'd4,    4'h3, 1'b1},
    '{2'd0, 10'd5,   10'd4,    4'h0, 1'b1},
    '{2'd1, 10'd0,   10'd0,    4'h9, 1'b0},
    '{2'd0, 10'd0,   10'd0,    4'h0, 1'b0},
    '{2'd2, 10'd0,   10'd7,    4'hC, 1'b1},
    '{2'd0, 10'd0,   10'd7,    4'h0, 1'b1},
    '{2'd0, 10'd1,   10'd0,    4'h0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int a0, c0, t;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes idle", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!req_ready && !init_done, "R1 not ready", int'(req_ready), 0);
    repeat (PAUSE - 5) @(negedge clk);
    chk(act_cnt + cbr_cnt == 0, "R1 no strobe during pause", act_cnt + cbr_cnt, 0);
    t = 0;
    while (!init_done && t < 1000) begin @(negedge clk); t++; end
    chk(cbr_cnt == NINIT, "R2 init refresh count", cbr_cnt, NINIT);
    chk(act_cnt == 0, "R2 no row-only cycle", act_cnt, 0);

    foreach (VECS[i])
      access(VECS[i].op, VECS[i].row, VECS[i].col, VECS[i].wd, VECS[i].last,
             VECS[i].op == 2'd2 ? "R5 rmw old data" : "R3 read data");

    chk(early_err == 0, "R4 we before cas", early_err, 0);
    chk(oe_err == 0, "R6 oe gating", oe_err, 0);

    // R7 page hits: one row-strobe fall for three accesses
    sync_refresh();
    a0 = act_cnt;
    access(2'd0, 10'd300, 10'd1, 4'h0, 1'b0, "R7 page read");
    access(2'd1, 10'd300, 10'd2, 4'h6, 1'b0, "R7 page write");
    access(2'd0, 10'd300, 10'd2, 4'h0, 1'b1, "R7 page readback");
    chk(act_cnt - a0 == 1, "R7 single activate", act_cnt - a0, 1);

    // R8 row change closes the page
    a0 = act_cnt;
    access(2'd1, 10'd10, 10'd0, 4'h1, 1'b0, "R8 row a write");
    access(2'd1, 10'd11, 10'd0, 4'h2, 1'b1, "R8 row b write");
    chk(act_cnt - a0 == 2, "R8 row change activates", act_cnt - a0, 2);
    access(2'd0, 10'd10, 10'd0, 4'h0, 1'b1, "R8 row a readback");
    access(2'd0, 10'd11, 10'd0, 4'h0, 1'b1, "R8 row b readback");

    // R8 page limit closes an idle page
    sync_refresh();
    access(2'd0, 10'd20, 10'd0, 4'h0, 1'b0, "R8 open page read");
    repeat (RASP + 20) @(negedge clk);
    chk(ras_n == 1'b1, "R8 page closed at limit", int'(ras_n), 1);
    chk(lo_max <= RASP, "R8 ras low bound", lo_max, RASP);

    // R9 refresh closes an open page before the limit
    sync_refresh();
    repeat (REFI - 100) @(negedge clk);
    c0 = cbr_cnt;
    access(2'd0, 10'd40, 10'd0, 4'h0, 1'b0, "R9 open page read");
    t = 0;
    while (cbr_cnt == c0 && t < 400) begin @(negedge clk); t++; end
    chk(cbr_cnt == c0 + 1 && t < 300, "R9 refresh preempts page", t, 300);

    // R9 periodic refresh rate
    repeat (30) @(negedge clk);
    c0 = cbr_cnt;
    repeat (4000) @(negedge clk);
    chk(cbr_cnt - c0 >= 4 && cbr_cnt - c0 <= 6, "R9 refresh rate", cbr_cnt - c0, 5);

    chk(rp_err == 0, "R10 precharge time", rp_err, 0);
    chk(rcd_err == 0, "R10 ras to cas delay", rcd_err, 0);
    chk(oe_err == 0, "R6 oe gating final", oe_err, 0);
    chk(lo_max <= RASP, "R8 ras low bound final", lo_max, RASP);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule